// File: doc/BRIEF.md
# Power-Gated Periodic Input Sampler

This block reads a group of open-drain status lines at a fixed, slow rate. The pull-up network behind those lines is powered only for the short time around each read, which saves battery. A free-running period timer starts each sample cycle. At the start of a cycle the block drives an active-low power enable low. It then waits a fixed number of clock cycles so the lines can settle, latches every line at once into a held register, and releases the enable on that same clock edge.

Downstream logic reads three outputs: the held sample, a one-cycle strobe that marks each new capture, and a flag that shows whether the new capture differs from the one before it. The period (128 ms) and the settle wait (56 µs) are parameters. By default both are derived from the clock frequency, and a bench or an integrator can override them with cycle counts. The period timer keeps counting while the block waits for the lines to settle. Cycle starts are therefore spaced exactly one period apart whatever the settle length, which must be at least one cycle and shorter than the period.

In the requirements, P is the period in clock cycles and S is the settle wait in clock cycles. Edge k is the k-th rising clock edge after the edge at which reset was last sampled high. For edge k ≥ P, the period phase is m = (k − P) mod P.

Top module: `power_gated_sampler`

## Requirements
- R1: After synchronous reset, the enable output `pwr_en_n` is 1, `sample` is all zeros, `sample_vld` is 0 and `sample_chg` is 0.
- R2: The enable first goes low at edge P, one full period after reset is released. It stays high at every edge k < P.
- R3: For k ≥ P, the enable is low after edge k when m < S and high when m ≥ S, so it is low for exactly S cycles in each period.
- R4: Cycle starts (falling edges of the enable) occur every P cycles. The settle wait does not stretch the period.
- R5: At the edge where m = S, `sample` loads the value on `lines` at that edge, bit i from `lines[i]`. This is the last cycle in which the enable was low.
- R6: `sample_vld` is 1 for the single cycle after each edge where m = S, and 0 otherwise. While it is 1 the enable is high.
- R7: At each capture, `sample_chg` becomes 1 if the new sample differs in any bit from the previously held one (all zeros after reset), and 0 if they are equal. It holds its value between captures.
- R8: Changes on `lines` at any edge other than a capture edge have no effect: `sample` and `sample_chg` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lines | input | N_LINES | Open-drain status lines, read only when captured |
| pwr_en_n | output | 1 | Active-low enable that powers the pull-ups |
| sample | output | N_LINES | Most recently captured line values |
| sample_vld | output | 1 | One-cycle strobe marking a new capture |
| sample_chg | output | 1 | New capture differs from the previous one |

## Verification
The assertions assume that `lines` is stable around each rising clock edge. They also assume that the parameters satisfy 1 ≤ S < P and P ≥ 2, and that reset is held for at least one edge before any check applies. The bench changes `lines` only on falling edges and uses a short period and settle count so that many cycles fit in one run. Random line values alternate with held stretches, including all-zeros and all-ones, so that captures both with and without a change are exercised. A reset is also applied in the middle of a period.

// File: rtl/sampler_pkg.sv
package sampler_pkg;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_SETTLE
    } seq_state_e;

    function automatic int unsigned cycles_for_us(input longint unsigned clk_hz,
                                                  input longint unsigned usec);
        longint unsigned prod;
        prod = clk_hz * usec;
        return int'(prod / 64'd1_000_000);
    endfunction

endpackage

// File: rtl/period_timer.sv
module period_timer #(
    parameter int unsigned PERIOD_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R4
endmodule

// File: rtl/settle_sequencer.sv
module settle_sequencer
    import sampler_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic en_n,
    output logic capture
);
    localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] LAST = SW'(SETTLE_CYC - 1);

    seq_state_e    state;
    logic [SW-1:0] scnt;

    assign capture = (state == SEQ_SETTLE) && (scnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            scnt  <= '0;
            en_n  <= 1'b1;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (tick) begin
                        state <= SEQ_SETTLE;
                        scnt  <= '0;
                        en_n  <= 1'b0;
                    end
                end
                SEQ_SETTLE: begin
                    if (capture) begin
                        state <= SEQ_IDLE;
                        en_n  <= 1'b1;
                    end else begin
                        scnt <= scnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    AST_START_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(en_n) |-> $past(tick)); // R4
    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_SETTLE) |-> (scnt <= LAST)); // R3
    AST_ENABLE_MATCHES_STATE: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_SETTLE) |-> !en_n); // R3
endmodule

// File: rtl/sample_capture.sv
module sample_capture #(
    parameter int unsigned N_LINES = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [N_LINES-1:0] lines,
    output logic [N_LINES-1:0] sample,
    output logic               vld,
    output logic               chg
);
    typedef struct packed {
        logic [N_LINES-1:0] value;
        logic               vld;
        logic               chg;
    } cap_t;

    cap_t cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (capture) begin
            cur.value <= lines;
            cur.vld   <= 1'b1;
            cur.chg   <= (lines != cur.value);
        end else begin
            cur.vld   <= 1'b0;
        end
    end

    assign sample = cur.value;
    assign vld    = cur.vld;
    assign chg    = cur.chg;

    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !vld |-> $stable(sample)); // R8
    AST_CHG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !vld |-> $stable(chg)); // R7
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld); // R6
endmodule

// File: rtl/power_gated_sampler.sv
module power_gated_sampler
    import sampler_pkg::*;
#(
    parameter int unsigned N_LINES    = 6,
    parameter int unsigned CLK_HZ     = 125_000_000,
    parameter int unsigned PERIOD_CYC = cycles_for_us(CLK_HZ, 128_000),
    parameter int unsigned SETTLE_CYC = cycles_for_us(CLK_HZ, 56)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lines,
    output logic               pwr_en_n,
    output logic [N_LINES-1:0] sample,
    output logic               sample_vld,
    output logic               sample_chg
);
    logic tick;
    logic capture;

    period_timer #(.PERIOD_CYC(PERIOD_CYC)) i_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    settle_sequencer #(.SETTLE_CYC(SETTLE_CYC)) i_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .en_n    (pwr_en_n),
        .capture (capture)
    );

    sample_capture #(.N_LINES(N_LINES)) i_cap (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .lines   (lines),
        .sample  (sample),
        .vld     (sample_vld),
        .chg     (sample_chg)
    );

    AST_VLD_ENABLE_OFF: assert property (@(posedge clk) disable iff (rst)
        sample_vld |-> pwr_en_n); // R6
    AST_RELEASE_WITH_VLD: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_en_n) |-> sample_vld); // R5
endmodule

// File: tb/test_power_gated_sampler.sv
module test_power_gated_sampler;
    localparam int N = 6;
    localparam int P = 200;
    localparam int S = 7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] lines = '0;
    logic         pwr_en_n;
    logic [N-1:0] sample;
    logic         sample_vld;
    logic         sample_chg;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit hold   = 1'b0;
    logic [N-1:0] hold_val = '0;

    always #4 clk = ~clk;

    power_gated_sampler #(
        .N_LINES(N), .PERIOD_CYC(P), .SETTLE_CYC(S)
    ) i_power_gated_sampler (
        .clk(clk), .rst(rst), .lines(lines), .pwr_en_n(pwr_en_n),
        .sample(sample), .sample_vld(sample_vld), .sample_chg(sample_chg)
    );

    // reference model, updated on each rising edge
    int           k = 0;
    bit           started = 1'b0;
    logic         e_en_n = 1'b1;
    logic [N-1:0] e_sample = '0;
    logic         e_vld = 1'b0;
    logic         e_chg = 1'b0;

    function automatic int phase(input int kk);
        return (kk - P) % P;
    endfunction

    function automatic logic en_expected(input int kk);
        if (kk < P) return 1'b1;
        return (phase(kk) < S) ? 1'b0 : 1'b1;
    endfunction

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            k = 0; e_en_n = 1'b1; e_sample = '0; e_vld = 1'b0; e_chg = 1'b0;
        end else begin
            k = k + 1;
            e_en_n = en_expected(k);
            if (k >= P && phase(k) == S) begin
                e_chg    = (lines != e_sample);
                e_sample = lines;
                e_vld    = 1'b1;
            end else begin
                e_vld = 1'b0;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s k=%0d actual=%0h expected=%0h", req, what, k, act, exp);
        end
    endtask

    // compare outputs away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            string rq_en;
            rq_en = (k == 0) ? "R1" : (k < P) ? "R2" : "R3";
            check(rq_en, "pwr_en_n", int'(pwr_en_n), int'(e_en_n));
            check((k == 0) ? "R1" : "R6", "sample_vld", int'(sample_vld), int'(e_vld));
            check((k == 0) ? "R1" : (e_vld ? "R5" : "R8"), "sample", int'(sample), int'(e_sample));
            check((k == 0) ? "R1" : "R7", "sample_chg", int'(sample_chg), int'(e_chg));
            if (!rst && k >= P && phase(k) == 0)
                check("R4", "cycle start", int'(pwr_en_n), 0);
            if (hold) lines <= hold_val;
            else      lines <= N'($urandom);
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        wait_cycles(3);
        @(negedge clk) rst = 1'b0;
        wait_cycles(6 * P);
        // R7 directed: identical inputs on consecutive captures -> no change
        hold_val = '1; hold = 1'b1;
        wait_cycles(3 * P);
        hold_val = '0;
        wait_cycles(3 * P);
        hold = 1'b0;
        wait_cycles(5 * P + 37);
        // reset in the middle of a period
        @(negedge clk) rst = 1'b1;
        wait_cycles(2);
        @(negedge clk) rst = 1'b0;
        wait_cycles(8 * P);
        @(negedge clk) done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_cycles(150_000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule